// File: doc/BRIEF.md
# Logarithmic gradient orientation binner

This block turns the four edge neighbours of a pixel into a gradient magnitude and one of nine orientation bins spanning -90 to +90 degrees. It forms the horizontal gradient as right minus left and the vertical gradient as lower minus upper. The magnitude is the sum of their absolute values. No multiplier, divider or arctangent is used.

To classify the orientation, the block looks up scaled base-2 logarithms of both absolute gradients and takes their difference, offset by a constant. It then counts how many fixed limits that difference exceeds. The signs of the two gradients choose which half of the bin range is used. One result is produced per input with a fixed two-cycle delay, and a new input can be accepted on every cycle. The block is meant to feed a histogram stage in a feature-extraction pipeline.

Top module: `log_orient_binner`

## Requirements
- R1: The horizontal gradient is gx = pix_right - pix_left and the vertical gradient is gy = pix_down - pix_up, with both operands taken as unsigned and the result as signed.
- R2: out_mag equals |gx| + |gy|.
- R3: The log table holds L(g) = round(32*log2(g)) for g >= 1 and L(0) = 0. Table inputs above the last entry saturate to it. The comparison value is V = 160 + L(|gy|) - L(|gx|).
- R4: The band is the number of limits in {80, 135, 168, 207, 347} that V strictly exceeds, capped at 4. A value of V at or below 80 gives band 0.
- R5: When gx and gy are both nonzero and of opposite sign, out_bin = 4 - band. When they are both nonzero and of the same sign, out_bin = 4 + band. Bin index k is centred on -80 + 20*k degrees.
- R6: When gx = 0 and gy != 0, out_bin is 8 for gy > 0 and 0 for gy < 0.
- R7: When gy = 0, out_bin is 4. When both gradients are 0, out_mag is 0 and out_bin is 4.
- R8: Any V at or above 347 gives the outermost bin (0 or 8) on the side chosen by the signs.
- R9: out_valid rises exactly two clock edges after in_valid is sampled high. out_valid is 0 after reset (rst_n active low).
- R10: Inputs presented on consecutive cycles each produce their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Neighbourhood is valid this cycle |
| pix_left | input | PIX_W | Left neighbour |
| pix_right | input | PIX_W | Right neighbour |
| pix_up | input | PIX_W | Upper neighbour |
| pix_down | input | PIX_W | Lower neighbour |
| out_valid | output | 1 | Result valid |
| out_mag | output | PIX_W+1 | Magnitude approximation |
| out_bin | output | 4 | Orientation bin 0..8 |

## Verification
Two results can be in the pipeline in the same cycle. While one sample's log difference is being classified, the next sample's gradients are being registered. A back-to-back burst of random neighbourhoods provokes this, and each result is compared two cycles later against a model built from the requirements. If any stage state leaked between the two samples, a bin or magnitude would show up one slot off. A second pairing joins the zero-gradient override with the sign selection. Cases with one gradient zero and the other of either sign show whether the override wins over the sign-based choice.

// File: rtl/log_orient_binner.sv
module log_orient_binner #(
  parameter int PIX_W     = 8,
  parameter int LUT_DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_left,
  input  logic [PIX_W-1:0] pix_right,
  input  logic [PIX_W-1:0] pix_up,
  input  logic [PIX_W-1:0] pix_down,
  output logic             out_valid,
  output logic [PIX_W:0]   out_mag,
  output logic [3:0]       out_bin
);
  localparam int GW   = PIX_W + 1;
  localparam int AW   = $clog2(LUT_DEPTH);
  localparam int LW   = 12;
  localparam int VW   = LW + 2;
  localparam int NTH  = 5;
  localparam int OFFS = 160;
  localparam int TH [NTH] = '{80, 135, 168, 207, 347};

  function automatic logic [LW-1:0] log_entry(input int g);
    real r;
    if (g <= 0) return '0;
    r = 32.0 * $ln(real'(g)) / $ln(2.0);
    return LW'($rtoi(r + 0.5));
  endfunction

  logic [LW-1:0] log_tab [LUT_DEPTH];
  for (genvar i = 0; i < LUT_DEPTH; i++) begin : g_tab
    assign log_tab[i] = log_entry(i);
  end

  // stage 1: gradients
  logic                 s1_vld;
  logic signed [GW-1:0] gx_q, gy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= in_valid;
    gx_q <= $signed({1'b0, pix_right}) - $signed({1'b0, pix_left});
    gy_q <= $signed({1'b0, pix_down})  - $signed({1'b0, pix_up});
  end

  // stage 2: magnitude and bin
  logic [GW-1:0]   gx_neg, gy_neg;
  logic [PIX_W-1:0] ax, ay;
  logic [AW-1:0]   ix, iy;
  logic signed [VW-1:0] v;
  logic [2:0]      band_raw, band;
  logic [3:0]      bin_c;

  assign gx_neg = GW'(-gx_q);
  assign gy_neg = GW'(-gy_q);
  assign ax = gx_q[GW-1] ? gx_neg[PIX_W-1:0] : gx_q[PIX_W-1:0];
  assign ay = gy_q[GW-1] ? gy_neg[PIX_W-1:0] : gy_q[PIX_W-1:0];
  assign ix = (int'(ax) > LUT_DEPTH - 1) ? AW'(LUT_DEPTH - 1) : AW'(ax);
  assign iy = (int'(ay) > LUT_DEPTH - 1) ? AW'(LUT_DEPTH - 1) : AW'(ay);
  assign v  = VW'(OFFS) + $signed({2'b00, log_tab[iy]}) - $signed({2'b00, log_tab[ix]});

  always_comb begin
    band_raw = '0;
    for (int t = 0; t < NTH; t++)
      if (int'(v) > TH[t]) band_raw = band_raw + 3'd1;
    band = (band_raw > 3'd4) ? 3'd4 : band_raw;
    if (ay == '0)
      bin_c = 4'd4;
    else if (ax == '0)
      bin_c = gy_q[GW-1] ? 4'd0 : 4'd8;
    else if (gx_q[GW-1] ^ gy_q[GW-1])
      bin_c = 4'd4 - {1'b0, band};
    else
      bin_c = 4'd4 + {1'b0, band};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_vld;
    out_mag <= {1'b0, ax} + {1'b0, ay};
    out_bin <= bin_c;
  end

  a_r9_stage1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_vld);
  a_r9_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_valid);
  a_r5_bin_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bin <= 4'd8);
  a_r7_zero_mag_centre: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mag == '0) |-> out_bin == 4'd4);
  a_r6_vertical_up: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && gx_q == '0 && gy_q > 0) |=> out_bin == 4'd8);
  a_r5_same_sign_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && gx_q > 0 && gy_q > 0) |=> out_bin >= 4'd4);
  a_r5_opp_sign_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && gx_q > 0 && gy_q < 0) |=> out_bin <= 4'd4);
endmodule

// File: tb/log_orient_binner_tb.sv
module log_orient_binner_tb;
  localparam int PIX_W = 8;
  localparam int NV = 14;
  localparam int NB = 24;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [PIX_W-1:0] pl = 0, pr = 0, pu = 0, pd = 0;
  logic out_valid;
  logic [PIX_W:0] out_mag;
  logic [3:0] out_bin;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  log_orient_binner u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_left(pl), .pix_right(pr), .pix_up(pu), .pix_down(pd),
    .out_valid(out_valid), .out_mag(out_mag), .out_bin(out_bin));

  // {left, right, up, down, mag, bin}
  localparam logic [44:0] VEC [NV] = '{
    {8'd0, 8'd10, 8'd5, 8'd5, 9'd10, 4'd4},    // R7 gy=0
    {8'd5, 8'd5, 8'd0, 8'd5, 9'd5, 4'd8},      // R6 gx=0 gy>0
    {8'd5, 8'd5, 8'd5, 8'd0, 9'd5, 4'd0},      // R6 gx=0 gy<0
    {8'd0, 8'd1, 8'd0, 8'd1, 9'd2, 4'd6},      // R4 V=160 band2
    {8'd0, 8'd1, 8'd1, 8'd0, 9'd2, 4'd2},      // R5 opposite sign
    {8'd0, 8'd255, 8'd0, 8'd1, 9'd256, 4'd4},  // R3 V=-96
    {8'd0, 8'd1, 8'd0, 8'd255, 9'd256, 4'd8},  // R8 V=416 clamp
    {8'd1, 8'd0, 8'd0, 8'd255, 9'd256, 4'd0},  // R8 clamp low side
    {8'd7, 8'd7, 8'd7, 8'd7, 9'd0, 4'd4},      // R7 both zero
    {8'd0, 8'd2, 8'd0, 8'd1, 9'd3, 4'd5},      // R4 V=128 band1
    {8'd0, 8'd1, 8'd0, 8'd2, 9'd3, 4'd7},      // R4 V=192 band3
    {8'd3, 8'd0, 8'd0, 8'd3, 9'd6, 4'd2},      // R1 gx<0 gy>0
    {8'd0, 8'd1, 8'd0, 8'd4, 9'd5, 4'd8},      // R4 V=224 band4
    {8'd2, 8'd0, 8'd1, 8'd0, 9'd3, 4'd5}       // R5 both negative
  };

  function automatic int lg(input int g);
    if (g <= 0) return 0;
    return $rtoi(32.0 * $ln(real'(g)) / $ln(2.0) + 0.5);
  endfunction

  function automatic void model(input int l, r, u, d, output int mag, output int bin);
    int gx, gy, ax, ay, v, band;
    gx = r - l; gy = d - u;
    ax = gx < 0 ? -gx : gx; ay = gy < 0 ? -gy : gy;
    mag = ax + ay;
    v = 160 + lg(ay) - lg(ax);
    band = (v > 80) + (v > 135) + (v > 168) + (v > 207) + (v > 347);
    if (band > 4) band = 4;
    if (ay == 0) bin = 4;
    else if (ax == 0) bin = gy > 0 ? 8 : 0;
    else if ((gx < 0) != (gy < 0)) bin = 4 - band;
    else bin = 4 + band;
  endfunction

  task automatic check(input string req, input logic v, input int mag, input int bin);
    checks++;
    if (out_valid !== v || (v && (out_mag !== 9'(mag) || out_bin !== 4'(bin)))) begin
      errors++;
      $display("FAIL %s: valid=%0b mag=%0d bin=%0d expected valid=%0b mag=%0d bin=%0d",
               req, out_valid, out_mag, out_bin, v, mag, bin);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bl [NB], br [NB], bu [NB], bd [NB];
    int m, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset", 1'b0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pl, pr, pu, pd} = VEC[i][44:13];
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check("R9 one-cycle gap", 1'b0, 0, 0);
      @(negedge clk);
      check($sformatf("R2/R5 vector %0d", i), 1'b1, int'(VEC[i][12:4]), int'(VEC[i][3:0]));
      @(negedge clk);
      check("R9 single pulse", 1'b0, 0, 0);
    end

    for (int i = 0; i < NB; i++) begin
      bl[i] = int'($urandom_range(0, 255)); br[i] = int'($urandom_range(0, 255));
      bu[i] = int'($urandom_range(0, 255)); bd[i] = int'($urandom_range(0, 255));
    end
    for (int i = 0; i < NB + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        model(bl[i-2], br[i-2], bu[i-2], bd[i-2], m, b);
        check($sformatf("R10 burst %0d", i - 2), 1'b1, m, b);
      end
      if (i < NB) begin
        pl = 8'(bl[i]); pr = 8'(br[i]); pu = 8'(bu[i]); pd = 8'(bd[i]);
        in_valid = 1;
      end else in_valid = 0;
    end

    @(negedge clk);
    pl = 0; pr = 9; pu = 0; pd = 3; in_valid = 1;
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    check("R9 reset clears pipeline", 1'b0, 0, 0);
    @(negedge clk);
    check("R9 after reset idle", 1'b0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule